// File: doc/BRIEF.md
# Frequency-Select Strap Capture and Clock Output Control

This block sits between the configuration register bank of a clock generator and its output buffers. Four board pins are shared between two uses. While power-on reset is held, and for a short programmable hold window after it, they are inputs that carry frequency-select straps. Their levels are then frozen in an internal latch, and the pins are handed over to the output drivers.

The block picks the active frequency code. The code comes either from the frozen straps or from a five-bit field scattered across the control byte. It also passes on the spread-enable and global tristate controls. For each clock output it keeps a gate enable that only changes while that output sits low, so disabling a clock never leaves a short pulse. It also builds the two readback bytes that software sees: the control byte with a revision code substituted while hardware selection is in force, and a strap byte holding the inverted latched levels.

Top module: `strap_ctl`

## Requirements
- R1: On every clock edge with `rst_n` low, `strap_oe` becomes 0, every bit of `gate_en` becomes 0 and the latched straps clear to 0, so `rd_strap` reads 8'h0F.
- R2: After `rst_n` goes high, `strap_oe` stays 0 for HOLD_CYC-1 edges. On the HOLD_CYC-th edge with `rst_n` high, `strap_in` is captured into the latch and `strap_oe` becomes 1. It stays 1 until the next reset.
- R3: Once `strap_oe` is 1, changes on `strap_in` have no effect on `freq_code` or `rd_strap` until the next reset.
- R4: With `ctrl_reg[3]`=0, `freq_code` = {1'b0, latched straps}, with strap 3 in bit 3 down to strap 0 in bit 0. With `ctrl_reg[3]`=1, `freq_code` = {ctrl_reg[7], ctrl_reg[2], ctrl_reg[6], ctrl_reg[5], ctrl_reg[4]}, most significant first.
- R5: `ssc_en` equals `ctrl_reg[1]` (1 = spread enabled).
- R6: `out_hiz` equals `ctrl_reg[0]`. While it is 1, every bit of `gate_en` is 0, whatever the enables hold.
- R7: On each edge with `rst_n` high, output i's gate state takes `en_mask[i]` only if `out_lvl[i]` is sampled 0 at that edge, and otherwise keeps its value. `gate_en[i]` shows that state when `out_hiz` is 0.
- R8: `rd_strap[3:0]` is the bitwise inverse of the latched straps, strap 0 in bit 0. `rd_strap[7:4]` is 0.
- R9: With `ctrl_reg[3]`=0, `rd_ctrl` is `ctrl_reg` with bits 7, 2, 6, 5, 4 replaced by REV_CODE[4] down to REV_CODE[0] in that order. With `ctrl_reg[3]`=1, `rd_ctrl` equals `ctrl_reg`.
- R10: `rate24_sel` equals `half_rate_sel`. A value of 1 selects the 24 MHz rate on the shared peripheral output and 0 selects 48 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| strap_in | input | 4 | Levels on the shared frequency-select pins |
| ctrl_reg | input | 8 | Function and frequency control byte |
| en_mask | input | N_OUT (28) | Per-output enable, 1 = active |
| out_lvl | input | N_OUT (28) | Current level of each raw output clock |
| half_rate_sel | input | 1 | Peripheral rate select from the register bank |
| freq_code | output | 5 | Active frequency code for the synthesizer |
| ssc_en | output | 1 | Spread modulation enable |
| out_hiz | output | 1 | Tristate all clock outputs |
| gate_en | output | N_OUT (28) | Per-output gate, 0 = held low |
| strap_oe | output | 1 | Shared pins direction, 1 = output |
| rate24_sel | output | 1 | Peripheral output at 24 MHz when 1 |
| rd_ctrl | output | 8 | Readback of the control byte |
| rd_strap | output | 8 | Readback of inverted latched straps |

## Verification
A hold counter that slips shows up as `strap_oe` rising one or more cycles early or late. It also changes which `strap_in` value is frozen, and that value then stays wrong in `freq_code` and `rd_strap` for the whole run. A latch that is not frozen follows the straps driven after capture and shows up in the very next cycle. A gate state updated while its output is high, or not updated when the output is low, differs from the reference on the cycle after that edge. Randomised levels and enables reach every output on many cycles, so such an error is seen within a few cycles.

// File: rtl/strap_ctl_pkg.sv
// Shared constants and helpers for the strap capture and output control block.
// Assumes the control byte layout: bit 3 source select, bit 1 spread, bit 0 tristate,
// bits 7,2,6,5,4 form the register frequency code (most significant first).
package strap_ctl_pkg;
    localparam int STRAP_W = 4;
    localparam int CODE_W  = 5;
    localparam int CTRL_W  = 8;
    localparam int BIT_SRC = 3;
    localparam int BIT_SSC = 1;
    localparam int BIT_HIZ = 0;

    // Gather the scattered register frequency field into one code.
    function automatic logic [CODE_W-1:0] gather_code(input logic [CTRL_W-1:0] c);
        return {c[7], c[2], c[6], c[5], c[4]};
    endfunction

    // Place a code back into the scattered field positions of a control byte.
    function automatic logic [CTRL_W-1:0] scatter_code(input logic [CTRL_W-1:0] c,
                                                       input logic [CODE_W-1:0] k);
        logic [CTRL_W-1:0] r;
        r    = c;
        r[7] = k[4];
        r[2] = k[3];
        r[6] = k[2];
        r[5] = k[1];
        r[4] = k[0];
        return r;
    endfunction
endpackage

// File: rtl/strap_capture.sv
// Holds the shared pins in input mode through reset and for HOLD_CYC edges after it,
// then freezes the strap levels and turns the pins to output mode.
// Assumes HOLD_CYC >= 1 and strap_in already synchronised to clk.
module strap_capture
    import strap_ctl_pkg::*;
#(
    parameter int HOLD_CYC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_in,
    output logic [STRAP_W-1:0] straps_q,
    output logic               pins_oe
);
    localparam int CNT_W = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);

    logic [CNT_W-1:0] hold_cnt;

    // Count the hold window, then capture the straps and release the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
            pins_oe  <= 1'b0;
            straps_q <= '0;
        end else if (!pins_oe) begin
            if (hold_cnt == CNT_W'(HOLD_CYC - 1)) begin
                straps_q <= strap_in;
                pins_oe  <= 1'b1;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end

    // R1: a reset edge always returns the pins to input mode.
    a_r1_input_in_reset: assert property (@(posedge clk) !rst_n |=> !pins_oe);

    // R2: output mode is kept until the next reset.
    a_r2_oe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        pins_oe |=> pins_oe);

    // R3: the latch is frozen once the pins have become outputs.
    a_r3_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        pins_oe |=> $stable(straps_q));
endmodule

// File: rtl/freq_route.sv
// Combinational selection of the frequency code and the readback bytes.
// Assumes straps_q is the frozen strap value (zero before capture).
module freq_route
    import strap_ctl_pkg::*;
#(
    parameter logic [CODE_W-1:0] REV_CODE = 5'b00010
) (
    input  logic [CTRL_W-1:0]  ctrl_reg,
    input  logic [STRAP_W-1:0] straps_q,
    output logic [CODE_W-1:0]  freq_code,
    output logic               ssc_en,
    output logic               out_hiz,
    output logic [CTRL_W-1:0]  rd_ctrl,
    output logic [CTRL_W-1:0]  rd_strap
);
    localparam int PAD_W = CODE_W - STRAP_W;
    localparam int RB_PAD = CTRL_W - STRAP_W;

    logic use_regs;
    assign use_regs = ctrl_reg[BIT_SRC];

    // Pick the code source and pass the mode bits through.
    always_comb begin
        freq_code = use_regs ? gather_code(ctrl_reg) : {{PAD_W{1'b0}}, straps_q};
        ssc_en    = ctrl_reg[BIT_SSC];
        out_hiz   = ctrl_reg[BIT_HIZ];
    end

    // Build the readback bytes.
    always_comb begin
        rd_ctrl  = use_regs ? ctrl_reg : scatter_code(ctrl_reg, REV_CODE);
        rd_strap = {{RB_PAD{1'b0}}, ~straps_q};
    end
endmodule

// File: rtl/gate_bank.sv
// One gate state per clock output. A state only loads its enable while that output
// is low, so gating never cuts a high phase short. Tristate forces all gates off.
// Assumes out_lvl is the raw output level sampled in the clk domain.
module gate_bank #(
    parameter int N_OUT = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_OUT-1:0] en_mask,
    input  logic [N_OUT-1:0] out_lvl,
    input  logic             hiz,
    output logic [N_OUT-1:0] gate_en
);
    logic [N_OUT-1:0] gate_q;

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        // Load the enable only while this output is low.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gate_q[i] <= 1'b0;
            end else if (!out_lvl[i]) begin
                gate_q[i] <= en_mask[i];
            end
        end

        // R7: a gate state may change only after an edge where its output was low.
        a_r7_change_on_low: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_q[i] != $past(gate_q[i])) |-> !$past(out_lvl[i]));
    end

    // Tristate takes priority over every enable.
    always_comb begin
        gate_en = hiz ? '0 : gate_q;
    end
endmodule

// File: rtl/strap_ctl.sv
// Top of the strap capture and output control block: strap latch, frequency source
// selection, readback bytes and per-output gating.
// Assumes all inputs are synchronous to clk and rst_n is a synchronous active-low reset.
module strap_ctl
    import strap_ctl_pkg::*;
#(
    parameter int                N_OUT    = 28,
    parameter int                HOLD_CYC = 4,
    parameter logic [4:0]        REV_CODE = 5'b00010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       strap_in,
    input  logic [7:0]       ctrl_reg,
    input  logic [N_OUT-1:0] en_mask,
    input  logic [N_OUT-1:0] out_lvl,
    input  logic             half_rate_sel,
    output logic [4:0]       freq_code,
    output logic             ssc_en,
    output logic             out_hiz,
    output logic [N_OUT-1:0] gate_en,
    output logic             strap_oe,
    output logic             rate24_sel,
    output logic [7:0]       rd_ctrl,
    output logic [7:0]       rd_strap
);
    logic [STRAP_W-1:0] straps_q;

    strap_capture #(.HOLD_CYC(HOLD_CYC)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_in (strap_in),
        .straps_q (straps_q),
        .pins_oe  (strap_oe)
    );

    freq_route #(.REV_CODE(REV_CODE)) u_route (
        .ctrl_reg  (ctrl_reg),
        .straps_q  (straps_q),
        .freq_code (freq_code),
        .ssc_en    (ssc_en),
        .out_hiz   (out_hiz),
        .rd_ctrl   (rd_ctrl),
        .rd_strap  (rd_strap)
    );

    gate_bank #(.N_OUT(N_OUT)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_mask (en_mask),
        .out_lvl (out_lvl),
        .hiz     (out_hiz),
        .gate_en (gate_en)
    );

    // Peripheral rate select passes straight to the divider.
    assign rate24_sel = half_rate_sel;

    // R8: before capture the strap readback shows the cleared latch.
    a_r8_blank_before_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_oe |-> (rd_strap == 8'h0F));

    // R1: a reset edge leaves every gate closed.
    a_r1_gates_closed: assert property (@(posedge clk) !rst_n |=> (gate_en == '0));
endmodule

// File: tb/strap_ctl_tb.sv
// Self-checking bench: behavioural reference updated each rising edge, outputs compared
// at each falling edge, inputs driven right after the comparison.
module strap_ctl_tb_top;
    localparam int N_OUT    = 28;
    localparam int HOLD_CYC = 4;
    localparam logic [4:0] REV = 5'b00010;
    localparam int WD_CYC   = 100000;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [3:0]       strap_in;
    logic [7:0]       ctrl_reg;
    logic [N_OUT-1:0] en_mask;
    logic [N_OUT-1:0] out_lvl;
    logic             half_rate_sel;
    logic [4:0]       freq_code;
    logic             ssc_en;
    logic             out_hiz;
    logic [N_OUT-1:0] gate_en;
    logic             strap_oe;
    logic             rate24_sel;
    logic [7:0]       rd_ctrl;
    logic [7:0]       rd_strap;

    int checks = 0;
    int errors = 0;
    bit armed  = 1'b0;

    always #2 clk = ~clk;

    strap_ctl #(.N_OUT(N_OUT), .HOLD_CYC(HOLD_CYC), .REV_CODE(REV)) dut_i (
        .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .ctrl_reg(ctrl_reg),
        .en_mask(en_mask), .out_lvl(out_lvl), .half_rate_sel(half_rate_sel),
        .freq_code(freq_code), .ssc_en(ssc_en), .out_hiz(out_hiz), .gate_en(gate_en),
        .strap_oe(strap_oe), .rate24_sel(rate24_sel), .rd_ctrl(rd_ctrl), .rd_strap(rd_strap)
    );

    // Reference state
    int               m_edges;
    bit               m_oe;
    logic [3:0]       m_str;
    logic [N_OUT-1:0] m_gate;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_edges = 0;
            m_oe    = 1'b0;
            m_str   = 4'h0;
            m_gate  = '0;
            armed   = 1'b1;
        end else begin
            m_edges = m_edges + 1;
            if (!m_oe && m_edges == HOLD_CYC) begin
                m_str = strap_in;
                m_oe  = 1'b1;
            end
            for (int i = 0; i < N_OUT; i++)
                if (out_lvl[i] == 1'b0) m_gate[i] = en_mask[i];
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [4:0] e_code;
        logic [7:0] e_rd;
        e_code = ctrl_reg[3] ? {ctrl_reg[7], ctrl_reg[2], ctrl_reg[6], ctrl_reg[5], ctrl_reg[4]}
                             : {1'b0, m_str};
        e_rd = ctrl_reg;
        if (!ctrl_reg[3]) begin
            e_rd[7] = REV[4]; e_rd[2] = REV[3]; e_rd[6] = REV[2];
            e_rd[5] = REV[1]; e_rd[4] = REV[0];
        end
        chk("R1/R2 strap_oe", 64'(strap_oe), 64'(m_oe));
        chk("R3/R4 freq_code", 64'(freq_code), 64'(e_code));
        chk("R5 ssc_en", 64'(ssc_en), 64'(ctrl_reg[1]));
        chk("R6 out_hiz", 64'(out_hiz), 64'(ctrl_reg[0]));
        chk("R6/R7 gate_en", 64'(gate_en), 64'(ctrl_reg[0] ? '0 : m_gate));
        chk("R8 rd_strap", 64'(rd_strap), 64'({4'h0, ~m_str}));
        chk("R9 rd_ctrl", 64'(rd_ctrl), 64'(e_rd));
        chk("R10 rate24_sel", 64'(rate24_sel), 64'(half_rate_sel));
    endtask

    task automatic cycle();
        @(negedge clk);
        if (armed) compare_all();
    endtask

    task automatic randomize_inputs(input bit move_straps);
        ctrl_reg      = 8'($urandom);
        en_mask       = N_OUT'($urandom);
        out_lvl       = N_OUT'($urandom);
        half_rate_sel = 1'($urandom);
        if (move_straps) strap_in = 4'($urandom);
    endtask

    task automatic reset_and_capture(input logic [3:0] pre, input logic [3:0] at_cap);
        rst_n = 1'b0;
        strap_in = pre;
        repeat (4) cycle();
        chk("R1 reset rd_strap", 64'(rd_strap), 64'h0F);
        chk("R1 reset strap_oe", 64'(strap_oe), 64'h0);
        rst_n = 1'b1;
        for (int k = 1; k <= HOLD_CYC; k++) begin
            strap_in = (k == HOLD_CYC) ? at_cap : ~at_cap;
            cycle();
            if (k < HOLD_CYC) chk("R2 hold window oe", 64'(strap_oe), 64'h0);
        end
        chk("R2 captured oe", 64'(strap_oe), 64'h1);
        chk("R8 captured readback", 64'(rd_strap), 64'({4'h0, ~at_cap}));
    endtask

    initial begin
        rst_n = 1'b0; strap_in = 4'hA; ctrl_reg = 8'h00; en_mask = '1;
        out_lvl = '0; half_rate_sel = 1'b0;
        @(negedge clk);
        reset_and_capture(4'hA, 4'h6);
        // R3: straps wiggle after capture; hardware code must stay at 6
        ctrl_reg = 8'h00;
        for (int k = 0; k < 8; k++) begin
            strap_in = 4'(k * 3);
            cycle();
            chk("R3 frozen code", 64'(freq_code), 64'h06);
        end
        // R6: tristate with all enables open, outputs low
        ctrl_reg = 8'h01; en_mask = '1; out_lvl = '0;
        cycle(); cycle();
        chk("R6 hiz gates closed", 64'(gate_en), 64'h0);
        // R7: outputs high, disable must wait
        ctrl_reg = 8'h00; out_lvl = '1; en_mask = '0;
        cycle(); cycle();
        chk("R7 held while high", 64'(gate_en), 64'(N_OUT'('1)));
        out_lvl = '0;
        cycle(); cycle();
        chk("R7 closed once low", 64'(gate_en), 64'h0);
        // R4/R9: register source selected
        ctrl_reg = 8'b1010_1100;
        cycle();
        chk("R4 reg code", 64'(freq_code), 64'b11010);
        chk("R9 reg readback", 64'(rd_ctrl), 64'hAC);
        for (int n = 0; n < 1500; n++) begin
            randomize_inputs(1'b1);
            cycle();
        end
        reset_and_capture(4'h3, 4'h1);
        for (int n = 0; n < 600; n++) begin
            randomize_inputs(1'b1);
            cycle();
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule